// File: doc/BRIEF.md
# Priority Match Resolver with Next-Match Stepping

This block sits behind the match lines of an associative memory array. When a compare cycle finishes, it captures the per-entry match vector. It reports the address of the winning entry, an active-low match flag and a multiple-match indication. Entry 0 has the highest priority, and priority falls as the index rises.

After a compare, a NEXT instruction retires the reported match and moves the report to the following matching entry. Repeated NEXT instructions walk every match in ascending index order until none are left, at which point the match flag goes high.

A move instruction copies the entry at the reported match address into the comparand register. The comparand register lives outside this block, so the block only drives a one-cycle write strobe, the data and a per-bit write enable chosen by a mask selector.

A single priority-in and priority-out pair lets several devices be chained. A device whose priority-in is low reports no match and passes low downstream.

Top module: `prio_match_resolver`

## Requirements
- R1: After reset, no match is held: `matchFlagN` is 1, `multiMatch` is 0, `cmpWe` is 0, `matchAddr` is 0, and `prioOut` follows `prioIn`.
- R2: `cmpValid` loads `matchVec`. From the next cycle, `matchAddr` is the lowest set index and `matchFlagN` is 0. It stays 0 while any loaded match remains.
- R3: `multiMatch` is 1 exactly when `prioIn` is 1 and two or more matches remain.
- R4: NEXT is encoded as `instOp` = 6'b011011, with `instValid`=1, `instHalfSel`=0, `prioIn`=1 and a match present. It retires the reported match, and `matchAddr` moves to the next higher set index in the following cycle.
- R5: A NEXT that retires the last remaining match sets `matchFlagN` to 1 and `matchAddr` to 0.
- R6: A compare reloads the vector and discards any NEXT progress. If `cmpValid` and a NEXT arrive in the same cycle, the NEXT is dropped and the new vector's first match is reported.
- R7: Move is encoded as `instOp` = 6'b001110 with `instHalfSel`=0. It reads the entry at `matchAddr` through `rdAddr`/`rdData`. In the next cycle, `cmpWe` pulses for one cycle with `cmpData` equal to that entry. With `instMaskSel`=0, `cmpBitEn` is all ones.
- R8: For a move with `instMaskSel` = n, where n is not 0, `cmpBitEn` is the bitwise inverse of mask register n. Only bits whose mask bit is 0 are written.
- R9: Any instruction with `instHalfSel`=1 is ignored: `matchAddr` and the flags are unchanged and `cmpWe` stays 0. Opcodes other than the two above are also ignored.
- R10: While `prioIn` is 0, `matchFlagN`=1, `multiMatch`=0 and `prioOut`=0. NEXT and move have no effect, and the held matches are reported again once `prioIn` returns to 1. `prioOut` is `prioIn` AND no local match.
- R11: A move issued while no match is reported leaves `cmpWe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare cycle complete; load matchVec |
| matchVec | input | ENTRIES | Per-entry match lines of the compare |
| instValid | input | 1 | Instruction strobe |
| instOp | input | 6 | Instruction opcode low bits |
| instMaskSel | input | 3 | Mask register selector (0 = no mask) |
| instHalfSel | input | 1 | Half-select; must be 0 for NEXT and move |
| prioIn | input | 1 | Priority-in from the device above (1 = allowed to report) |
| maskRegs | input | MASKS x WIDTH | Mask register contents (index 0 unused) |
| rdData | input | WIDTH | Entry word at rdAddr |
| rdAddr | output | ADDR_W | Entry read address (the reported match) |
| matchAddr | output | ADDR_W | Highest-priority remaining match address |
| matchFlagN | output | 1 | Active-low match flag |
| multiMatch | output | 1 | Two or more matches remain |
| prioOut | output | 1 | Priority-out to the device below |
| cmpWe | output | 1 | Comparand write strobe |
| cmpBitEn | output | WIDTH | Per-bit comparand write enable |
| cmpData | output | WIDTH | Comparand write data |

## Verification
The assertions assume that `rdData` returns the entry addressed by `rdAddr` combinationally in the same cycle. They also assume that instruction fields are stable across each clock edge and that `prioIn` is a plain level input. The stimulus drives every input just after a falling edge and models the entry array as a combinational function of `rdAddr`. The NEXT ordering check relies on the vector being reloaded only through `cmpValid`, and the stimulus changes the match vector only together with that strobe.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam logic [5:0] OP_NEXT = 6'b011011;
  localparam logic [5:0] OP_MOVE = 6'b001110;

  typedef struct packed {
    logic loadVec;
    logic advance;
    logic move;
  } prmStrobe_t;
endpackage

// File: rtl/prm_ctrl.sv
module prm_ctrl
  import prm_pkg::*;
(
  input  logic       cmpValid,
  input  logic       instValid,
  input  logic [5:0] instOp,
  input  logic       instHalfSel,
  input  logic       prioIn,
  input  logic       anyHit,
  output prmStrobe_t strobe
);
  logic instOk;
  logic localHit;

  always_comb begin
    instOk   = instValid && !instHalfSel;
    localHit = prioIn && anyHit;
    strobe.loadVec = cmpValid;
    // a compare cycle overrides a NEXT in the same cycle
    strobe.advance = instOk && (instOp == OP_NEXT) && localHit && !cmpValid;
    strobe.move    = instOk && (instOp == OP_MOVE) && localHit;
  end
endmodule

// File: rtl/prm_dpath.sv
module prm_dpath
  import prm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int MASKS   = 8,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(MASKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  prmStrobe_t                  strobe,
  input  logic [ENTRIES-1:0]          matchVec,
  input  logic [SEL_W-1:0]            instMaskSel,
  input  logic [MASKS-1:0][WIDTH-1:0] maskRegs,
  input  logic [WIDTH-1:0]            rdData,
  output logic [ADDR_W-1:0]           hitAddr,
  output logic                        anyHit,
  output logic                        multiHit,
  output logic                        cmpWe,
  output logic [WIDTH-1:0]            cmpBitEn,
  output logic [WIDTH-1:0]            cmpData
);
  logic [ENTRIES-1:0] remVec;
  logic [ENTRIES-1:0] belowSet;
  logic [ENTRIES-1:0] winner;
  logic [WIDTH-1:0]   bitEnNext;

  // one-hot winner: set bit with no set bit below it
  assign belowSet[0] = 1'b0;
  for (genvar i = 1; i < ENTRIES; i++) begin : g_chain
    assign belowSet[i] = belowSet[i-1] | remVec[i-1];
  end
  for (genvar i = 0; i < ENTRIES; i++) begin : g_win
    assign winner[i] = remVec[i] & ~belowSet[i];
  end

  always_comb begin
    hitAddr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (winner[i]) hitAddr |= ADDR_W'(i);
    end
  end

  assign anyHit   = |remVec;
  assign multiHit = |(remVec & ~winner);

  always_comb begin
    if (instMaskSel == '0) bitEnNext = '1;
    else                   bitEnNext = ~maskRegs[instMaskSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remVec <= '0;
    end else if (strobe.loadVec) begin
      remVec <= matchVec;
    end else if (strobe.advance) begin
      remVec <= remVec & ~winner;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpWe    <= 1'b0;
      cmpBitEn <= '0;
      cmpData  <= '0;
    end else begin
      cmpWe <= strobe.move;
      if (strobe.move) begin
        cmpBitEn <= bitEnNext;
        cmpData  <= rdData;
      end
    end
  end
endmodule

// File: rtl/prio_match_resolver.sv
module prio_match_resolver
  import prm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int MASKS   = 8,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(MASKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmpValid,
  input  logic [ENTRIES-1:0]          matchVec,
  input  logic                        instValid,
  input  logic [5:0]                  instOp,
  input  logic [SEL_W-1:0]            instMaskSel,
  input  logic                        instHalfSel,
  input  logic                        prioIn,
  input  logic [MASKS-1:0][WIDTH-1:0] maskRegs,
  input  logic [WIDTH-1:0]            rdData,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic [ADDR_W-1:0]           matchAddr,
  output logic                        matchFlagN,
  output logic                        multiMatch,
  output logic                        prioOut,
  output logic                        cmpWe,
  output logic [WIDTH-1:0]            cmpBitEn,
  output logic [WIDTH-1:0]            cmpData
);
  prmStrobe_t strobe;
  logic anyHit;
  logic multiHit;
  logic [ADDR_W-1:0] hitAddr;

  prm_ctrl u_ctrl (
    .cmpValid   (cmpValid),
    .instValid  (instValid),
    .instOp     (instOp),
    .instHalfSel(instHalfSel),
    .prioIn     (prioIn),
    .anyHit     (anyHit),
    .strobe     (strobe)
  );

  prm_dpath #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .MASKS(MASKS)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .matchVec   (matchVec),
    .instMaskSel(instMaskSel),
    .maskRegs   (maskRegs),
    .rdData     (rdData),
    .hitAddr    (hitAddr),
    .anyHit     (anyHit),
    .multiHit   (multiHit),
    .cmpWe      (cmpWe),
    .cmpBitEn   (cmpBitEn),
    .cmpData    (cmpData)
  );

  assign matchAddr  = hitAddr;
  assign rdAddr     = hitAddr;
  assign matchFlagN = !(prioIn && anyHit);
  assign multiMatch = prioIn && multiHit;
  assign prioOut    = prioIn && !anyHit;
endmodule

// File: rtl/prm_checker.sv
module prm_checker
  import prm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int MASKS   = 8,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(MASKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmpValid,
  input logic              instValid,
  input logic [5:0]        instOp,
  input logic [SEL_W-1:0]  instMaskSel,
  input logic              instHalfSel,
  input logic              prioIn,
  input logic [ADDR_W-1:0] matchAddr,
  input logic              matchFlagN,
  input logic              multiMatch,
  input logic              prioOut,
  input logic              cmpWe,
  input logic [WIDTH-1:0]  cmpBitEn
);
  // R3
  multi_implies_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    multiMatch |-> !matchFlagN);

  // R4
  next_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instOp == OP_NEXT && !instHalfSel && !cmpValid && prioIn && !matchFlagN)
      |=> (matchFlagN || matchAddr > $past(matchAddr)));

  // R7
  move_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpWe |-> ($past(instValid) && $past(instOp) == OP_MOVE && !$past(instHalfSel)));

  // R7
  move_nomask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWe && $past(instMaskSel) == '0) |-> (&cmpBitEn));

  // R9
  halfsel_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instHalfSel && !cmpValid) |=> ($stable(matchAddr) && !cmpWe));

  // R10
  chain_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prioIn |-> (matchFlagN && !multiMatch && !prioOut));
endmodule

bind prio_match_resolver prm_checker #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .MASKS(MASKS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmpValid   (cmpValid),
  .instValid  (instValid),
  .instOp     (instOp),
  .instMaskSel(instMaskSel),
  .instHalfSel(instHalfSel),
  .prioIn     (prioIn),
  .matchAddr  (matchAddr),
  .matchFlagN (matchFlagN),
  .multiMatch (multiMatch),
  .prioOut    (prioOut),
  .cmpWe      (cmpWe),
  .cmpBitEn   (cmpBitEn)
);

// File: tb/prio_match_resolver_test.sv
`timescale 1ns/1ps
module prio_match_resolver_test;
  localparam int ENTRIES = 16;
  localparam int WIDTH   = 64;
  localparam int MASKS   = 8;
  localparam int ADDR_W  = $clog2(ENTRIES);
  localparam logic [5:0] NEXT_OP = 6'b011011;
  localparam logic [5:0] MOVE_OP = 6'b001110;

  logic clk = 1'b0;
  logic rstN;
  logic cmpValid;
  logic [ENTRIES-1:0] matchVec;
  logic instValid;
  logic [5:0] instOp;
  logic [2:0] instMaskSel;
  logic instHalfSel;
  logic prioIn;
  logic [MASKS-1:0][WIDTH-1:0] maskRegs;
  logic [WIDTH-1:0] rdData;
  logic [ADDR_W-1:0] rdAddr, matchAddr;
  logic matchFlagN, multiMatch, prioOut, cmpWe;
  logic [WIDTH-1:0] cmpBitEn, cmpData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [WIDTH-1:0] entryWord(input int idx);
    return {32'hC0DE0000 + 32'(idx), 32'h5A5A0000 ^ (32'(idx) << 4)};
  endfunction

  assign rdData = entryWord(int'(rdAddr));

  prio_match_resolver #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .MASKS(MASKS)) uut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .matchVec(matchVec),
    .instValid(instValid), .instOp(instOp), .instMaskSel(instMaskSel),
    .instHalfSel(instHalfSel), .prioIn(prioIn), .maskRegs(maskRegs),
    .rdData(rdData), .rdAddr(rdAddr), .matchAddr(matchAddr),
    .matchFlagN(matchFlagN), .multiMatch(multiMatch), .prioOut(prioOut),
    .cmpWe(cmpWe), .cmpBitEn(cmpBitEn), .cmpData(cmpData)
  );

  task automatic chk(input string req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected report after a vector state: lowest set index, flags
  task automatic chkState(input string req, input logic [ENTRIES-1:0] v);
    int first = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (v[i]) first = i;
    chk(req, "matchAddr", WIDTH'(matchAddr), WIDTH'(first));
    chk(req, "matchFlagN", WIDTH'(matchFlagN), WIDTH'(v == '0));
    chk(req, "multiMatch", WIDTH'(multiMatch), WIDTH'($countones(v) >= 2));
  endtask

  // one clock with the given inputs, then idle inputs
  task automatic cycle(input logic cv, input logic [ENTRIES-1:0] mv,
                       input logic iv, input logic [5:0] op,
                       input logic [2:0] sel, input logic hs);
    @(negedge clk);
    cmpValid = cv; matchVec = mv; instValid = iv; instOp = op;
    instMaskSel = sel; instHalfSel = hs;
    @(posedge clk); #1;
    cmpValid = 1'b0; instValid = 1'b0; instOp = '0; instMaskSel = '0; instHalfSel = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "matchFlagN", WIDTH'(matchFlagN), 1);
    chk("R1", "multiMatch", WIDTH'(multiMatch), 0);
    chk("R1", "cmpWe", WIDTH'(cmpWe), 0);
    chk("R1", "matchAddr", WIDTH'(matchAddr), 0);
    chk("R1", "prioOut", WIDTH'(prioOut), 1);
  endtask

  task automatic testWalk();
    logic [ENTRIES-1:0] v = 16'b1010_0000_0010_0100;
    cycle(1, v, 0, '0, 0, 0);
    chkState("R2", v);
    chk("R10", "prioOut with match", WIDTH'(prioOut), 0);
    while (v != '0) begin
      logic [ENTRIES-1:0] nv = v & (v - 1'b1);
      cycle(0, '0, 1, NEXT_OP, 0, 0);
      chkState((nv == '0) ? "R5" : "R4", nv);
      chk("R3", "multi", WIDTH'(multiMatch), WIDTH'($countones(nv) >= 2));
      v = nv;
    end
    cycle(0, '0, 1, NEXT_OP, 0, 0);
    chkState("R5", '0);
  endtask

  task automatic testSingle();
    cycle(1, 16'h0080, 0, '0, 0, 0);
    chkState("R3", 16'h0080);
  endtask

  task automatic testOverride();
    cycle(1, 16'h000A, 0, '0, 0, 0);
    cycle(0, '0, 1, NEXT_OP, 0, 0);
    chkState("R4", 16'h0008);
    cycle(1, 16'h0210, 1, NEXT_OP, 0, 0);
    chkState("R6", 16'h0210);
  endtask

  task automatic testMove();
    cycle(1, 16'h0040, 0, '0, 0, 0);
    cycle(0, '0, 1, MOVE_OP, 0, 0);
    chk("R7", "cmpWe", WIDTH'(cmpWe), 1);
    chk("R7", "cmpData", cmpData, entryWord(6));
    chk("R7", "cmpBitEn", cmpBitEn, '1);
    cycle(0, '0, 0, '0, 0, 0);
    chk("R7", "cmpWe pulse end", WIDTH'(cmpWe), 0);
    cycle(1, 16'h0104, 0, '0, 0, 0);
    cycle(0, '0, 1, NEXT_OP, 0, 0);
    cycle(0, '0, 1, MOVE_OP, 3, 0);
    chk("R8", "cmpWe", WIDTH'(cmpWe), 1);
    chk("R8", "cmpData", cmpData, entryWord(8));
    chk("R8", "cmpBitEn", cmpBitEn, ~maskRegs[3]);
    cycle(0, '0, 1, MOVE_OP, 5, 0);
    chk("R8", "cmpBitEn sel5", cmpBitEn, ~maskRegs[5]);
  endtask

  task automatic testIgnored();
    cycle(1, 16'h0C00, 0, '0, 0, 0);
    cycle(0, '0, 1, NEXT_OP, 0, 1);
    chkState("R9", 16'h0C00);
    cycle(0, '0, 1, MOVE_OP, 0, 1);
    chk("R9", "cmpWe halfsel", WIDTH'(cmpWe), 0);
    cycle(0, '0, 1, 6'b011000, 0, 0);
    chkState("R9", 16'h0C00);
  endtask

  task automatic testChain();
    cycle(1, 16'h0030, 0, '0, 0, 0);
    @(negedge clk); prioIn = 1'b0;
    #1;
    chk("R10", "matchFlagN", WIDTH'(matchFlagN), 1);
    chk("R10", "multiMatch", WIDTH'(multiMatch), 0);
    chk("R10", "prioOut", WIDTH'(prioOut), 0);
    cycle(0, '0, 1, NEXT_OP, 0, 0);
    cycle(0, '0, 1, MOVE_OP, 0, 0);
    chk("R10", "cmpWe blocked", WIDTH'(cmpWe), 0);
    @(negedge clk); prioIn = 1'b1;
    #1;
    chkState("R10", 16'h0030);
  endtask

  task automatic testMoveNoMatch();
    cycle(1, 16'h0000, 0, '0, 0, 0);
    cycle(0, '0, 1, MOVE_OP, 0, 0);
    chk("R11", "cmpWe", WIDTH'(cmpWe), 0);
    chk("R11", "prioOut", WIDTH'(prioOut), 1);
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishUp();
  end

  initial begin
    for (int m = 0; m < MASKS; m++)
      maskRegs[m] = {32'h0F0F0000 ^ 32'(m * 32'h1111), 32'hFF00_00FF ^ 32'(m << 8)};
    rstN = 1'b0; cmpValid = 1'b0; matchVec = '0; instValid = 1'b0;
    instOp = '0; instMaskSel = '0; instHalfSel = 1'b0; prioIn = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testWalk();
    testSingle();
    testOverride();
    testMove();
    testIgnored();
    testChain();
    testMoveNoMatch();
    finishUp();
  end
endmodule